// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt sources and offers the processor one of them at a time, together with an 8-bit vector number. The processor uses that number to index its handler address table. The vector space has two parts. Vectors 0 to 31 belong to internal fault events, which can never be masked. Vectors 32 and up belong to device sources, which can be masked. Fault vectors drive the nonmaskable request line. Device vectors drive the maskable request line.

Fault events are pulses, and each one is held pending until the processor acknowledges it. Device requests are levels, gated by a per-device enable bit that is written through a small write port. The controller keeps one in-service bit per vector. A request can only preempt the work already in progress if its priority is strictly higher than the highest-priority vector in service. A lower vector number means a higher priority.

The controller samples requests only at instruction boundaries. The processor signals a boundary with a one-cycle strobe. After that, the processor acknowledges the offered vector and later sends an end-of-interrupt pulse.

Top module: `intr_vector_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it, both request lines are low and the vector output is 0. Every device enable bit resets to 0.
- R2: A one-cycle pulse on fault input bit v (0 to 31) makes vector v pending. At the next boundary, vector v is offered on the nonmaskable line, whatever the state of the global mask and the enable bits.
- R3: Device source i maps to vector 32+i. While its request is high and its enable bit is set, it is offered on the maskable line at a boundary. A device request that has gone low is not pending.
- R4: The global mask keeps device vectors from being chosen at a boundary. It also pulls the maskable line low in the same cycle it is raised. It has no effect on fault vectors or on the nonmaskable line.
- R5: When several vectors are eligible, the lowest vector number is offered. At most one request line is high at any time.
- R6: The offered vector and the request lines change only on a clock edge where the boundary strobe is high, or on an acknowledge. A change in pending requests between boundaries leaves the outputs unchanged. A later boundary re-selects, so a better candidate can replace the one on offer.
- R7: An acknowledge while a line is high does four things on the next edge: it drops both lines, sets the in-service bit of the offered vector, clears that vector's pending bit if it is a fault, and leaves the vector output unchanged.
- R8: A vector is eligible only if its number is strictly lower than the lowest in-service vector. Requests of equal or lower priority wait.
- R9: An end-of-interrupt pulse clears only the lowest-numbered in-service bit. Requests it was blocking can then be offered at the next boundary.
- R10: A write with the enable-write strobe high sets the enable bit of the selected device to the supplied value. A disabled device is never offered.
- R11: If a fault pulse and the acknowledge of that same fault vector arrive on the same edge, the fault stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_evt | input | 32 | Fault event pulses; bit v raises vector v |
| dev_req | input | NUM_DEV | Level-sensitive device requests; bit i raises vector 32+i |
| en_we | input | 1 | Enable-write strobe |
| en_sel | input | DEV_W | Device index selected by the enable write |
| en_val | input | 1 | Value written to the selected enable bit |
| gmask | input | 1 | Global mask for device vectors |
| instr_done | input | 1 | Instruction-boundary strobe |
| cpu_ack | input | 1 | One-cycle acknowledge from the processor |
| eoi | input | 1 | End-of-interrupt pulse |
| nmi_req | output | 1 | Nonmaskable request (fault vector offered) |
| irq_req | output | 1 | Maskable request (device vector offered) |
| vector | output | 8 | Offered vector number |

## Verification
Each result has a fixed latency:
- A vector becomes visible on the outputs one edge after the boundary strobe is sampled.
- An acknowledge drops the lines one edge after it is sampled.
- A fault pulse is only captured into the pending state on its own edge, so at least one boundary must follow it before that fault can be offered.
- Raising the global mask pulls the maskable line low with no edge at all.

The bench drives every stimulus for exactly one clock and samples one time unit after the edge that must carry the result. It samples the mask case before any edge. It also waits through several edges with no boundary, to show that the outputs hold.

// File: rtl/intr_vector_ctrl.sv
module intr_vector_ctrl #(
  parameter int NUM_DEV = 224,
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        fault_evt,
  input  logic [NUM_DEV-1:0] dev_req,
  input  logic               en_we,
  input  logic [DEV_W-1:0]   en_sel,
  input  logic               en_val,
  input  logic               gmask,
  input  logic               instr_done,
  input  logic               cpu_ack,
  input  logic               eoi,
  output logic               nmi_req,
  output logic               irq_req,
  output logic [7:0]         vector
);
  localparam int TOTAL = 32 + NUM_DEV;

  logic [31:0]        flt_pend;
  logic [NUM_DEV-1:0] dev_en;
  logic [TOTAL-1:0]   in_svc, pend, elig, ack_set, eoi_clr;
  logic               pres_v, cand_v, svc_v, taken;
  logic [7:0]         pres_vec, cand_vec, svc_top;

  assign pend  = {dev_req & dev_en, flt_pend};
  assign taken = cpu_ack & (nmi_req | irq_req);

  always_comb begin
    svc_v   = 1'b0;
    svc_top = '0;
    for (int i = TOTAL - 1; i >= 0; i--)
      if (in_svc[i]) begin
        svc_v   = 1'b1;
        svc_top = 8'(i);
      end
  end

  always_comb
    for (int i = 0; i < TOTAL; i++)
      elig[i] = pend[i] & ~in_svc[i] & (!svc_v || i < int'(svc_top)) & (i < 32 || !gmask);

  always_comb begin
    cand_v   = 1'b0;
    cand_vec = '0;
    for (int i = TOTAL - 1; i >= 0; i--)
      if (elig[i]) begin
        cand_v   = 1'b1;
        cand_vec = 8'(i);
      end
  end

  assign ack_set = taken ? ({{(TOTAL-1){1'b0}}, 1'b1} << pres_vec) : '0;
  assign eoi_clr = (eoi && svc_v) ? ({{(TOTAL-1){1'b0}}, 1'b1} << svc_top) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_pend <= '0;
      in_svc   <= '0;
      dev_en   <= '0;
      pres_v   <= 1'b0;
      pres_vec <= '0;
    end else begin
      flt_pend <= (flt_pend & ~ack_set[31:0]) | fault_evt;
      in_svc   <= (in_svc & ~eoi_clr) | ack_set;
      if (en_we && int'(en_sel) < NUM_DEV)
        dev_en[en_sel] <= en_val;
      if (taken)
        pres_v <= 1'b0;
      else if (instr_done) begin
        pres_v   <= cand_v;
        pres_vec <= cand_vec;
      end
    end

  assign nmi_req = pres_v & (pres_vec < 8'd32);
  assign irq_req = pres_v & (pres_vec >= 8'd32) & ~gmask;
  assign vector  = pres_vec;
endmodule

// File: rtl/intr_vector_ctrl_chk.sv
module intr_vector_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       instr_done,
  input logic       cpu_ack,
  input logic       nmi_req,
  input logic       irq_req,
  input logic [7:0] vector
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!nmi_req && !irq_req && vector == 8'd0));

  a_r2_nmi_fault_range: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> vector < 8'd32);

  a_r3_irq_dev_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> vector >= 8'd32);

  a_r5_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nmi_req, irq_req}));

  a_r6_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done |=> $stable(vector));

  a_r7_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && (nmi_req || irq_req)) |=> (!nmi_req && !irq_req));
endmodule

bind intr_vector_ctrl intr_vector_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .cpu_ack(cpu_ack),
  .nmi_req(nmi_req), .irq_req(irq_req), .vector(vector)
);

// File: tb/sim_intr_vector_ctrl.sv
module sim_intr_vector_ctrl;
  localparam int ND = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] fault_evt = '0;
  logic [ND-1:0] dev_req = '0;
  logic en_we = 1'b0, en_val = 1'b0, gmask = 1'b0;
  logic [2:0] en_sel = '0;
  logic instr_done = 1'b0, cpu_ack = 1'b0, eoi = 1'b0;
  logic nmi_req, irq_req;
  logic [7:0] vector;
  int checks = 0, fails = 0;

  intr_vector_ctrl #(.NUM_DEV(ND)) u0 (
    .clk(clk), .rst_n(rst_n), .fault_evt(fault_evt), .dev_req(dev_req),
    .en_we(en_we), .en_sel(en_sel), .en_val(en_val), .gmask(gmask),
    .instr_done(instr_done), .cpu_ack(cpu_ack), .eoi(eoi),
    .nmi_req(nmi_req), .irq_req(irq_req), .vector(vector));

  always #2.5 clk = ~clk;

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic expect_out(string rq, logic en, logic ei, int ev);
    checks++;
    if ({nmi_req, irq_req} !== {en, ei} || ((en | ei) && vector !== 8'(ev))) begin
      fails++;
      $display("FAIL %s: nmi/irq/vec=%b/%b/%0d expected %b/%b/%0d",
               rq, nmi_req, irq_req, vector, en, ei, ev);
    end
  endtask

  task automatic boundary(); instr_done = 1'b1; tick(); instr_done = 1'b0; endtask
  task automatic ack(); cpu_ack = 1'b1; tick(); cpu_ack = 1'b0; endtask
  task automatic end_irq(); eoi = 1'b1; tick(); eoi = 1'b0; endtask
  task automatic fault(int v); fault_evt[v] = 1'b1; tick(); fault_evt[v] = 1'b0; endtask
  task automatic set_en(int i, logic val);
    en_we = 1'b1; en_sel = 3'(i); en_val = val; tick(); en_we = 1'b0;
  endtask
  task automatic raise(int v);
    if (v < 32) fault(v); else dev_req[v-32] = 1'b1;
  endtask
  task automatic serve(string rq, int v);
    boundary();
    expect_out(rq, v < 32, v >= 32, v);
    ack();
    expect_out({rq, " ack"}, 1'b0, 1'b0, 0);
    checks++;
    if (vector !== 8'(v)) begin
      fails++;
      $display("FAIL R7: vector after ack=%0d expected %0d", vector, v);
    end
    if (v >= 32) dev_req[v-32] = 1'b0;
    end_irq();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, all requirements incomplete");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    expect_out("R1", 1'b0, 1'b0, 0);
    checks++;
    if (vector !== 8'd0) begin
      fails++;
      $display("FAIL R1: vector=%0d expected 0", vector);
    end
    rst_n = 1'b1;
    tick();
    // R1 / R10: enables reset to 0, so a device request is not offered
    dev_req[0] = 1'b1;
    boundary();
    expect_out("R1 enables off", 1'b0, 1'b0, 0);
    dev_req[0] = 1'b0;

    // R6: no boundary -> nothing offered
    fault(4);
    repeat (3) tick();
    expect_out("R6 no boundary", 1'b0, 1'b0, 0);
    serve("R2", 4);
    boundary();
    expect_out("R7 pending cleared", 1'b0, 1'b0, 0);

    // R2 sweep of all fault vectors, mask toggled
    for (int v = 0; v < 32; v++) begin
      gmask = v[0];
      fault(v);
      serve("R2", v);
    end
    gmask = 1'b0;

    // R3 / R10 sweep of devices
    for (int i = 0; i < ND; i++) begin
      set_en(i, 1'b1);
      dev_req[i] = 1'b1;
      serve("R3", 32 + i);
    end
    set_en(3, 1'b0);
    dev_req[3] = 1'b1;
    boundary();
    expect_out("R10 disabled", 1'b0, 1'b0, 0);
    set_en(3, 1'b1);
    boundary();
    expect_out("R10 enabled", 1'b0, 1'b1, 35);
    ack();
    dev_req[3] = 1'b0;
    end_irq();

    // R4 global mask
    dev_req[1] = 1'b1;
    gmask = 1'b1;
    boundary();
    expect_out("R4 masked", 1'b0, 1'b0, 0);
    gmask = 1'b0;
    tick();
    expect_out("R6 unmask waits", 1'b0, 1'b0, 0);
    boundary();
    expect_out("R4 unmasked", 1'b0, 1'b1, 33);
    gmask = 1'b1;
    #1;
    expect_out("R4 line drops", 1'b0, 1'b0, 0);
    fault(9);
    boundary();
    expect_out("R4 nmi unaffected", 1'b1, 1'b0, 9);
    ack();
    end_irq();
    gmask = 1'b0;
    serve("R4", 33);

    // R5 all pairs
    for (int a = 0; a < 32 + ND; a++)
      for (int b = a + 1; b < 32 + ND; b++) begin
        raise(a);
        raise(b);
        serve("R5 first", a);
        serve("R5 second", b);
        boundary();
        expect_out("R5 empty", 1'b0, 1'b0, 0);
      end

    // R8 / R9 nesting
    dev_req[5] = 1'b1;
    boundary();
    expect_out("R8", 1'b0, 1'b1, 37);
    ack();
    dev_req[5] = 1'b0;
    dev_req[2] = 1'b1;
    boundary();
    expect_out("R8 preempt", 1'b0, 1'b1, 34);
    ack();
    dev_req[6] = 1'b1;
    boundary();
    expect_out("R8 equal/lower wait", 1'b0, 1'b0, 0);
    fault(3);
    boundary();
    expect_out("R8 fault preempts", 1'b1, 1'b0, 3);
    ack();
    end_irq();
    boundary();
    expect_out("R9 only lowest cleared", 1'b0, 1'b0, 0);
    end_irq();
    boundary();
    expect_out("R9 reoffer", 1'b0, 1'b1, 34);
    dev_req[2] = 1'b0;
    boundary();
    expect_out("R8 below in-service", 1'b0, 1'b0, 0);
    end_irq();
    boundary();
    expect_out("R9 released", 1'b0, 1'b1, 38);
    ack();
    dev_req[6] = 1'b0;
    end_irq();
    boundary();
    expect_out("R9 empty", 1'b0, 1'b0, 0);

    // R11 pulse coincides with ack
    fault(7);
    boundary();
    expect_out("R11", 1'b1, 1'b0, 7);
    fault_evt[7] = 1'b1;
    cpu_ack = 1'b1;
    tick();
    fault_evt[7] = 1'b0;
    cpu_ack = 1'b0;
    end_irq();
    boundary();
    expect_out("R11 still pending", 1'b1, 1'b0, 7);
    ack();
    end_irq();
    boundary();
    expect_out("R11 cleared", 1'b0, 1'b0, 0);

    // R6 replacement at a later boundary
    dev_req[4] = 1'b1;
    boundary();
    expect_out("R6", 1'b0, 1'b1, 36);
    fault(1);
    expect_out("R6 hold", 1'b0, 1'b1, 36);
    boundary();
    expect_out("R6 replace", 1'b1, 1'b0, 1);
    ack();
    end_irq();
    serve("R6", 36);

    summary();
    $finish;
  end
endmodule